// File: doc/BRIEF.md
# Flash Controller with Erase Gating

This block fronts a word-organised NOR-style flash array and a 64-word user configuration area. Software reaches it through three 32-bit request ports. The first is a control bank. It holds a ready status word, a two-bit configuration register, and the triggers for page erase, whole-array erase and user-area erase. The second is a data port that reads and programs flash words. The third is a plain read/write port into the user area.

Programming follows NOR rules: a write can only clear bits. Each erase path has its own gate. Page erase needs the erase-enable bit. Whole-array erase needs both the erase-enable bit and a key value. User-area erase needs only the key.

Every operation, erases included, finishes in the clock cycle that accepts it. Each port's ready output therefore stays high, and no port ever applies back-pressure. Each port returns read data with a valid strobe exactly one cycle after it accepts the read. That response cannot be stalled, so the requester must always be able to take it.

Top module: `nvm_ctrl`

## Requirements
- R1: While reset is held and just after it is released, the configuration register reads 0, every user-area word reads 0xFFFFFFFF, and all three response strobes are low.
- R2: A control read at offset 0x400 returns 1 (always ready). A control read at any offset other than 0x400 and 0x504 returns 0. Control writes to any offset other than 0x504, 0x508, 0x50C, 0x510 and 0x514 change nothing.
- R3: A write to offset 0x504 stores only bits [1:0]: bit 0 is write-enable and bit 1 is erase-enable. Reading it back returns those two bits with zeros above them.
- R4: With write-enable set, a flash write makes the addressed word equal to its old value ANDed with the written data. With write-enable clear, the write leaves the word unchanged.
- R5: With erase-enable set, a write to offset 0x508 or to offset 0x510 erases one page, and the two offsets behave identically. The written value is a byte address whose in-page bits are ignored. Every word of the selected page reads 0xFFFFFFFF afterwards, and the other pages are untouched.
- R6: A page-erase write changes nothing in either of two cases: erase-enable is clear, or the page-aligned address is above FLASH_BYTES minus PAGE_BYTES. The last page itself is erasable.
- R7: A write of 0x00000001 to offset 0x50C while erase-enable is set fills every flash word and every user-area word with ones. A write of any other value, or any write while erase-enable is clear, has no effect.
- R8: A write of 0x00000001 to offset 0x514 sets every user-area word to 0xFFFFFFFF whatever the configuration. A write of any other value there has no effect.
- R9: The user area behaves as a read/write register file, with the word index taken from address bits [7:2].
- R10: Requests are accepted in every cycle. A read response (strobe and data) appears exactly one cycle after the read request. The response reflects the state before any change made in that same cycle.
- R11: If an erase and a write hit the same word in one cycle, the erase wins and the word reads all ones.
- R12: Flash contents survive reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_valid | input | 1 | Control request valid |
| ctl_ready | output | 1 | Control request accepted (always 1) |
| ctl_write | input | 1 | Control request is a write |
| ctl_addr | input | 12 | Control byte offset |
| ctl_wdata | input | 32 | Control write data |
| ctl_rvalid | output | 1 | Control read data valid |
| ctl_rdata | output | 32 | Control read data |
| fl_valid | input | 1 | Flash request valid |
| fl_ready | output | 1 | Flash request accepted (always 1) |
| fl_write | input | 1 | Flash request is a program |
| fl_addr | input | FL_AW | Flash byte address (bits [1:0] ignored) |
| fl_wdata | input | 32 | Flash program data |
| fl_rvalid | output | 1 | Flash read data valid |
| fl_rdata | output | 32 | Flash read data |
| ua_valid | input | 1 | User-area request valid |
| ua_ready | output | 1 | User-area request accepted (always 1) |
| ua_write | input | 1 | User-area request is a write |
| ua_addr | input | 8 | User-area byte offset |
| ua_wdata | input | 32 | User-area write data |
| ua_rvalid | output | 1 | User-area read data valid |
| ua_rdata | output | 32 | User-area read data |

## Verification
The properties assume three things about the inputs: each port carries at most one request per cycle, every request input holds steady around the sampling edge, and read responses are never refused. The properties on flash read data also assume the array was first cleared by a whole-array erase, because its power-up contents are undefined. The stimulus drives every input just after a rising edge and holds it for a full cycle. It issues the whole-array erase before it reads any flash word. It crosses ports only in the deliberate same-cycle collisions that exercise erase priority and read-before-change ordering.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  localparam int unsigned CTL_AW = 12;
  localparam int unsigned DW     = 32;

  localparam logic [CTL_AW-1:0] OFF_READY    = 12'h400;
  localparam logic [CTL_AW-1:0] OFF_CFG      = 12'h504;
  localparam logic [CTL_AW-1:0] OFF_PG_ERA_A = 12'h508;
  localparam logic [CTL_AW-1:0] OFF_ERA_ALL  = 12'h50C;
  localparam logic [CTL_AW-1:0] OFF_PG_ERA_B = 12'h510;
  localparam logic [CTL_AW-1:0] OFF_UA_ERA   = 12'h514;

  localparam logic [DW-1:0] CFG_MASK  = 32'h0000_0003;
  localparam logic [DW-1:0] ERASE_KEY = 32'h0000_0001;

  typedef struct packed {
    logic een;
    logic wen;
  } cfg_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_READY,
    SEL_CFG,
    SEL_PG_ERA,
    SEL_ERA_ALL,
    SEL_UA_ERA
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [CTL_AW-1:0] a);
    reg_sel_e s;
    case (a)
      OFF_READY:                  s = SEL_READY;
      OFF_CFG:                    s = SEL_CFG;
      OFF_PG_ERA_A, OFF_PG_ERA_B: s = SEL_PG_ERA;
      OFF_ERA_ALL:                s = SEL_ERA_ALL;
      OFF_UA_ERA:                 s = SEL_UA_ERA;
      default:                    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/nvm_cfg_regs.sv
module nvm_cfg_regs
  import nvm_pkg::*;
#(
  parameter int unsigned FLASH_BYTES = 4096,
  parameter int unsigned PAGE_BYTES  = 1024,
  localparam int unsigned NUM_PAGES  = FLASH_BYTES / PAGE_BYTES,
  localparam int unsigned PG_LSB     = $clog2(PAGE_BYTES),
  localparam int unsigned PG_W       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_valid,
  input  logic              ctl_write,
  input  logic [CTL_AW-1:0] ctl_addr,
  input  logic [DW-1:0]     ctl_wdata,
  output logic              ctl_rvalid,
  output logic [DW-1:0]     ctl_rdata,
  output cfg_t              cfg,
  output logic              pg_erase,
  output logic [PG_W-1:0]   pg_idx,
  output logic              erase_all,
  output logic              ua_clear
);

  localparam logic [DW-1:0] PAGE_MASK = ~(DW'(PAGE_BYTES) - 32'd1);
  localparam logic [DW-1:0] LAST_PAGE = DW'(FLASH_BYTES - PAGE_BYTES);

  cfg_t          cfg_q;
  reg_sel_e      sel;
  logic          wr_acc;
  logic          rd_acc;
  logic [DW-1:0] aligned;
  logic          in_range;
  logic          key_ok;
  logic [DW-1:0] rd_mux;

  assign sel      = decode_off(ctl_addr);
  assign wr_acc   = ctl_valid && ctl_write;
  assign rd_acc   = ctl_valid && !ctl_write;
  assign aligned  = ctl_wdata & PAGE_MASK;
  assign in_range = (aligned <= LAST_PAGE);
  assign key_ok   = (ctl_wdata == ERASE_KEY);

  // Erase gates look at the configuration held before this cycle's write.
  assign pg_erase  = wr_acc && (sel == SEL_PG_ERA) && cfg_q.een && in_range;
  assign pg_idx    = aligned[PG_LSB +: PG_W];
  assign erase_all = wr_acc && (sel == SEL_ERA_ALL) && cfg_q.een && key_ok;
  assign ua_clear  = erase_all || (wr_acc && (sel == SEL_UA_ERA) && key_ok);
  assign cfg       = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_acc && (sel == SEL_CFG)) begin
      cfg_q <= cfg_t'(2'(ctl_wdata & CFG_MASK));
    end
  end

  always_comb begin
    case (sel)
      SEL_READY: rd_mux = 32'd1;
      SEL_CFG:   rd_mux = {30'd0, cfg_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_rvalid <= 1'b0;
      ctl_rdata  <= '0;
    end else begin
      ctl_rvalid <= rd_acc;
      if (rd_acc) ctl_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/nvm_flash_array.sv
module nvm_flash_array
  import nvm_pkg::*;
#(
  parameter int unsigned FLASH_BYTES = 4096,
  parameter int unsigned PAGE_BYTES  = 1024,
  localparam int unsigned WORDS      = FLASH_BYTES / 4,
  localparam int unsigned WPP        = PAGE_BYTES / 4,
  localparam int unsigned NUM_PAGES  = FLASH_BYTES / PAGE_BYTES,
  localparam int unsigned WW         = $clog2(WORDS),
  localparam int unsigned OFF_W      = $clog2(WPP),
  localparam int unsigned PG_W       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic [WW-1:0]   rd_word,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  input  logic            wr_en,
  input  logic [WW-1:0]   wr_word,
  input  logic [DW-1:0]   wr_data,
  input  logic            pg_erase,
  input  logic [PG_W-1:0] pg_idx,
  input  logic            erase_all
);

  logic [DW-1:0]    mem [WORDS];
  logic [WORDS-1:0] live_all;   // 1: word programmed since its last erase
  logic [PG_W-1:0]  wr_page;
  logic [OFF_W-1:0] wr_off;
  logic [DW-1:0]    wr_old;
  logic [DW-1:0]    rd_word_val;

  assign wr_page = wr_word[OFF_W +: PG_W];
  assign wr_off  = wr_word[OFF_W-1:0];

  // Per-page live bits: an erase clears a whole page in one cycle and wins
  // over a program to the same page. Not reset: flash survives reset.
  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    logic [WPP-1:0] live_q;
    logic           hit_erase;
    logic           hit_write;

    assign hit_erase = erase_all || (pg_erase && (pg_idx == PG_W'(p)));
    assign hit_write = wr_en && (wr_page == PG_W'(p));

    always_ff @(posedge clk) begin
      if (hit_erase) begin
        live_q <= '0;
      end else if (hit_write) begin
        live_q[wr_off] <= 1'b1;
      end
    end

    assign live_all[p*WPP +: WPP] = live_q;
  end

  assign wr_old      = live_all[wr_word] ? mem[wr_word] : '1;
  assign rd_word_val = live_all[rd_word] ? mem[rd_word] : '1;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_word] <= wr_old & wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= rd_word_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end

endmodule

// File: rtl/nvm_user_area.sv
module nvm_user_area
  import nvm_pkg::*;
#(
  parameter int unsigned UA_WORDS = 64,
  localparam int unsigned IDX_W   = $clog2(UA_WORDS),
  localparam int unsigned UA_AW   = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [UA_AW-1:0] req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rvalid,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0]    regs [UA_WORDS];
  logic [IDX_W-1:0] idx;
  logic [1:0]       unused_lsb;

  assign idx        = req_addr[UA_AW-1:2];
  assign unused_lsb = req_addr[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < UA_WORDS; i++) regs[i] <= '1;
    end else if (clear) begin
      for (int i = 0; i < UA_WORDS; i++) regs[i] <= '1;
    end else if (req_valid && req_write) begin
      regs[idx] <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= req_valid && !req_write;
      if (req_valid && !req_write) rdata <= regs[idx];
    end
  end

endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int unsigned FLASH_BYTES = 4096,
  parameter int unsigned PAGE_BYTES  = 1024,
  parameter int unsigned UA_WORDS    = 64,
  localparam int unsigned FL_AW      = $clog2(FLASH_BYTES),
  localparam int unsigned UA_AW      = $clog2(UA_WORDS) + 2,
  localparam int unsigned NUM_PAGES  = FLASH_BYTES / PAGE_BYTES,
  localparam int unsigned PG_W       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_valid,
  output logic              ctl_ready,
  input  logic              ctl_write,
  input  logic [CTL_AW-1:0] ctl_addr,
  input  logic [DW-1:0]     ctl_wdata,
  output logic              ctl_rvalid,
  output logic [DW-1:0]     ctl_rdata,
  input  logic              fl_valid,
  output logic              fl_ready,
  input  logic              fl_write,
  input  logic [FL_AW-1:0]  fl_addr,
  input  logic [DW-1:0]     fl_wdata,
  output logic              fl_rvalid,
  output logic [DW-1:0]     fl_rdata,
  input  logic              ua_valid,
  output logic              ua_ready,
  input  logic              ua_write,
  input  logic [UA_AW-1:0]  ua_addr,
  input  logic [DW-1:0]     ua_wdata,
  output logic              ua_rvalid,
  output logic [DW-1:0]     ua_rdata
);

  cfg_t              cfg_bits;
  logic              pg_erase;
  logic [PG_W-1:0]   pg_idx;
  logic              erase_all;
  logic              ua_clear;
  logic [FL_AW-3:0]  fl_word;
  logic [1:0]        unused_fl_lsb;

  // Every operation completes in its accept cycle: no port ever stalls.
  assign ctl_ready = 1'b1;
  assign fl_ready  = 1'b1;
  assign ua_ready  = 1'b1;

  assign fl_word       = fl_addr[FL_AW-1:2];
  assign unused_fl_lsb = fl_addr[1:0];

  nvm_cfg_regs #(
    .FLASH_BYTES(FLASH_BYTES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_valid (ctl_valid),
    .ctl_write (ctl_write),
    .ctl_addr  (ctl_addr),
    .ctl_wdata (ctl_wdata),
    .ctl_rvalid(ctl_rvalid),
    .ctl_rdata (ctl_rdata),
    .cfg       (cfg_bits),
    .pg_erase  (pg_erase),
    .pg_idx    (pg_idx),
    .erase_all (erase_all),
    .ua_clear  (ua_clear)
  );

  nvm_flash_array #(
    .FLASH_BYTES(FLASH_BYTES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (fl_valid && !fl_write),
    .rd_word  (fl_word),
    .rd_valid (fl_rvalid),
    .rd_data  (fl_rdata),
    .wr_en    (fl_valid && fl_write && cfg_bits.wen),
    .wr_word  (fl_word),
    .wr_data  (fl_wdata),
    .pg_erase (pg_erase),
    .pg_idx   (pg_idx),
    .erase_all(erase_all)
  );

  nvm_user_area #(
    .UA_WORDS(UA_WORDS)
  ) u_ua (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ua_clear),
    .req_valid(ua_valid),
    .req_write(ua_write),
    .req_addr (ua_addr),
    .req_wdata(ua_wdata),
    .rvalid   (ua_rvalid),
    .rdata    (ua_rdata)
  );

endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk
  import nvm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_valid,
  input logic              ctl_write,
  input logic [CTL_AW-1:0] ctl_addr,
  input logic [DW-1:0]     ctl_wdata,
  input logic              ctl_rvalid,
  input logic [DW-1:0]     ctl_rdata,
  input logic              fl_valid,
  input logic              fl_write,
  input logic              fl_rvalid,
  input logic [DW-1:0]     fl_rdata,
  input logic              ua_valid,
  input logic              ua_write,
  input logic              ua_rvalid,
  input logic [DW-1:0]     ua_rdata,
  input logic              een
);

  assert_ctl_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && !ctl_write) |=> ctl_rvalid);

  assert_fl_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_valid && !fl_write) |=> !fl_rvalid);

  assert_ua_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ua_valid && !ua_write) |=> ua_rvalid);

  assert_ready_reads_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && !ctl_write && ctl_addr == OFF_READY) |=> (ctl_rdata == 32'd1));

  assert_undef_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && !ctl_write && ctl_addr != OFF_READY && ctl_addr != OFF_CFG)
      |=> (ctl_rdata == 32'd0));

  assert_cfg_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && !ctl_write && ctl_addr == OFF_CFG) |=> (ctl_rdata[31:2] == 30'd0));

  assert_ua_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_write && ctl_addr == OFF_UA_ERA && ctl_wdata == ERASE_KEY)
      ##1 (ua_valid && !ua_write) |=> (ua_rdata == '1));

  assert_all_erased_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_write && ctl_addr == OFF_ERA_ALL && ctl_wdata == ERASE_KEY && een)
      ##1 (fl_valid && !fl_write) |=> (fl_rdata == '1));

endmodule

bind nvm_ctrl nvm_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_valid (ctl_valid),
  .ctl_write (ctl_write),
  .ctl_addr  (ctl_addr),
  .ctl_wdata (ctl_wdata),
  .ctl_rvalid(ctl_rvalid),
  .ctl_rdata (ctl_rdata),
  .fl_valid  (fl_valid),
  .fl_write  (fl_write),
  .fl_rvalid (fl_rvalid),
  .fl_rdata  (fl_rdata),
  .ua_valid  (ua_valid),
  .ua_write  (ua_write),
  .ua_rvalid (ua_rvalid),
  .ua_rdata  (ua_rdata),
  .een       (cfg_bits.een)
);

// File: tb/sim_nvm_ctrl.sv
`timescale 1ns/1ps
module sim_nvm_ctrl;

  localparam int FLASH_BYTES = 4096;
  localparam int PAGE_BYTES  = 1024;
  localparam int WORDS       = FLASH_BYTES / 4;
  localparam int WPP         = PAGE_BYTES / 4;
  localparam int FL_AW       = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_valid, ctl_write, ctl_ready, ctl_rvalid;
  logic [11:0] ctl_addr;
  logic [31:0] ctl_wdata, ctl_rdata;
  logic        fl_valid, fl_write, fl_ready, fl_rvalid;
  logic [FL_AW-1:0] fl_addr;
  logic [31:0] fl_wdata, fl_rdata;
  logic        ua_valid, ua_write, ua_ready, ua_rvalid;
  logic [7:0]  ua_addr;
  logic [31:0] ua_wdata, ua_rdata;

  always #5 clk = ~clk;

  nvm_ctrl #(.FLASH_BYTES(FLASH_BYTES), .PAGE_BYTES(PAGE_BYTES)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_write(ctl_write),
    .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rvalid(ctl_rvalid), .ctl_rdata(ctl_rdata),
    .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_write(fl_write),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata),
    .ua_valid(ua_valid), .ua_ready(ua_ready), .ua_write(ua_write),
    .ua_addr(ua_addr), .ua_wdata(ua_wdata), .ua_rvalid(ua_rvalid), .ua_rdata(ua_rdata)
  );

  int    checks = 0;
  int    fails  = 0;
  string cur_tag = "R1";

  // Behavioural reference model
  logic [31:0] m_fl [WORDS];
  logic [31:0] m_ua [64];
  logic [1:0]  m_cfg;
  bit          m_known = 0;
  logic        e_crv, e_frv, e_urv;
  logic [31:0] e_crd, e_frd, e_urd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 2'b00;
      for (int i = 0; i < 64; i++) m_ua[i] = 32'hFFFF_FFFF;
      e_crv = 0; e_frv = 0; e_urv = 0;
    end else begin
      logic        een;
      logic [31:0] al;
      e_crv = ctl_valid && !ctl_write;
      if (e_crv) e_crd = (ctl_addr == 12'h400) ? 32'd1 :
                         (ctl_addr == 12'h504) ? {30'd0, m_cfg} : 32'd0;
      e_frv = fl_valid && !fl_write;
      if (e_frv) e_frd = m_fl[fl_addr[FL_AW-1:2]];
      e_urv = ua_valid && !ua_write;
      if (e_urv) e_urd = m_ua[ua_addr[7:2]];
      if (fl_valid && fl_write && m_cfg[0])
        m_fl[fl_addr[FL_AW-1:2]] = m_fl[fl_addr[FL_AW-1:2]] & fl_wdata;
      if (ua_valid && ua_write) m_ua[ua_addr[7:2]] = ua_wdata;
      if (ctl_valid && ctl_write) begin
        een = m_cfg[1];
        case (ctl_addr)
          12'h504: m_cfg = ctl_wdata[1:0];
          12'h508, 12'h510: begin
            al = ctl_wdata & ~(PAGE_BYTES - 1);
            if (een && al <= FLASH_BYTES - PAGE_BYTES)
              for (int i = 0; i < WPP; i++) m_fl[al/4 + i] = 32'hFFFF_FFFF;
          end
          12'h50C: if (een && ctl_wdata == 32'd1) begin
            for (int i = 0; i < WORDS; i++) m_fl[i] = 32'hFFFF_FFFF;
            for (int i = 0; i < 64; i++) m_ua[i] = 32'hFFFF_FFFF;
            m_known = 1;
          end
          12'h514: if (ctl_wdata == 32'd1)
            for (int i = 0; i < 64; i++) m_ua[i] = 32'hFFFF_FFFF;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk({31'd0, ctl_rvalid}, {31'd0, e_crv}, "R10 ctl_rvalid");
    chk({31'd0, fl_rvalid},  {31'd0, e_frv}, "R10 fl_rvalid");
    chk({31'd0, ua_rvalid},  {31'd0, e_urv}, "R10 ua_rvalid");
    chk({29'd0, ctl_ready, fl_ready, ua_ready}, 32'd7, "R10 ready");
    if (e_crv) chk(ctl_rdata, e_crd, {cur_tag, " model ctl"});
    if (e_frv && m_known) chk(fl_rdata, e_frd, {cur_tag, " model flash"});
    if (e_urv) chk(ua_rdata, e_urd, {cur_tag, " model ua"});
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic idle();
    ctl_valid = 0; ctl_write = 0;
    fl_valid = 0;  fl_write = 0;
    ua_valid = 0;  ua_write = 0;
  endtask

  task automatic set_ctl(input logic w, input logic [11:0] a, input logic [31:0] d);
    ctl_valid = 1; ctl_write = w; ctl_addr = a; ctl_wdata = d;
  endtask

  task automatic ctl_wr(input logic [11:0] a, input logic [31:0] d);
    set_ctl(1, a, d); step(); idle();
  endtask

  task automatic ctl_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    set_ctl(0, a, 0); step(); idle();
    chk(ctl_rdata, exp, tag);
  endtask

  task automatic fl_wr(input int w, input logic [31:0] d);
    fl_valid = 1; fl_write = 1; fl_addr = FL_AW'(w * 4); fl_wdata = d; step(); idle();
  endtask

  task automatic fl_rd(input int w, input logic [31:0] exp, input string tag);
    fl_valid = 1; fl_write = 0; fl_addr = FL_AW'(w * 4); step(); idle();
    chk(fl_rdata, exp, tag);
  endtask

  task automatic ua_wr(input int w, input logic [31:0] d);
    ua_valid = 1; ua_write = 1; ua_addr = 8'(w * 4); ua_wdata = d; step(); idle();
  endtask

  task automatic ua_rd(input int w, input logic [31:0] exp, input string tag);
    ua_valid = 1; ua_write = 0; ua_addr = 8'(w * 4); step(); idle();
    chk(ua_rdata, exp, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; ctl_addr = 0; ctl_wdata = 0; fl_addr = 0; fl_wdata = 0;
    ua_addr = 0; ua_wdata = 0;
    idle();
    // R1: reset state
    repeat (3) step();
    rst_n = 1;
    ctl_rd(12'h504, 32'd0, "R1 cfg after reset");
    ua_rd(5, 32'hFFFF_FFFF, "R1 ua after reset");
    ua_rd(63, 32'hFFFF_FFFF, "R1 ua last after reset");

    // R2: ready and undefined offsets
    cur_tag = "R2";
    ctl_rd(12'h400, 32'd1, "R2 ready");
    ctl_rd(12'h000, 32'd0, "R2 undefined read");
    ctl_rd(12'h508, 32'd0, "R2 trigger read zero");
    ctl_wr(12'h600, 32'h3);
    ctl_rd(12'h504, 32'd0, "R2 undefined write ignored");

    // R3: configuration mask
    cur_tag = "R3";
    ctl_wr(12'h504, 32'hFFFF_FFFF);
    ctl_rd(12'h504, 32'd3, "R3 mask all ones");
    ctl_wr(12'h504, 32'h0000_0006);
    ctl_rd(12'h504, 32'd2, "R3 mask erase-enable only");

    // R7: whole erase establishes known flash
    cur_tag = "R7";
    ctl_wr(12'h50C, 32'd1);
    fl_rd(0, 32'hFFFF_FFFF, "R7 erase all word 0");
    fl_rd(WORDS - 1, 32'hFFFF_FFFF, "R7 erase all last word");

    // R4: program clears bits only, gated by write-enable
    cur_tag = "R4";
    ctl_wr(12'h504, 32'd0);
    fl_wr(10, 32'h0);
    fl_rd(10, 32'hFFFF_FFFF, "R4 write blocked");
    ctl_wr(12'h504, 32'd1);
    fl_wr(10, 32'hF0F0_FFFF);
    fl_rd(10, 32'hF0F0_FFFF, "R4 first program");
    fl_wr(10, 32'h0F0F_FFFF);
    fl_rd(10, 32'h0000_FFFF, "R4 AND of programs");
    fl_wr(10, 32'hFFFF_FFFF);
    fl_rd(10, 32'h0000_FFFF, "R4 ones do not set bits");

    // R5: page erase on both offsets
    cur_tag = "R5";
    fl_wr(WPP + 3, 32'h1234_5678);
    fl_wr(2 * WPP + 7, 32'h0BAD_F00D);
    ctl_wr(12'h504, 32'd3);
    ctl_wr(12'h508, 32'h0000_05F3);
    fl_rd(WPP + 3, 32'hFFFF_FFFF, "R5 page 1 erased via 0x508");
    fl_rd(2 * WPP + 7, 32'h0BAD_F00D, "R5 page 2 untouched");
    fl_rd(10, 32'h0000_FFFF, "R5 page 0 untouched");
    ctl_wr(12'h510, 32'h0000_0800);
    fl_rd(2 * WPP + 7, 32'hFFFF_FFFF, "R5 page 2 erased via 0x510");

    // R6: page erase dropped when disabled or out of range
    cur_tag = "R6";
    fl_wr(WPP + 44, 32'h0);
    ctl_wr(12'h504, 32'd1);
    ctl_wr(12'h508, 32'h0000_0400);
    fl_rd(WPP + 44, 32'h0, "R6 erase-enable clear");
    ctl_wr(12'h504, 32'd3);
    ctl_wr(12'h508, 32'h0000_1000);
    ctl_wr(12'h510, 32'hFFFF_FC00);
    fl_rd(WPP + 44, 32'h0, "R6 out of range dropped");
    fl_wr(3 * WPP + 1, 32'h5555_0000);
    ctl_wr(12'h510, 32'h0000_0C00);
    fl_rd(3 * WPP + 1, 32'hFFFF_FFFF, "R6 last page erasable");

    // R7: key and gate
    cur_tag = "R7";
    ua_wr(9, 32'hCAFE_0001);
    ctl_wr(12'h50C, 32'd2);
    fl_rd(WPP + 44, 32'h0, "R7 wrong key ignored");
    ctl_wr(12'h504, 32'd1);
    ctl_wr(12'h50C, 32'd1);
    fl_rd(WPP + 44, 32'h0, "R7 erase-enable clear ignored");
    ua_rd(9, 32'hCAFE_0001, "R7 ua kept when gated");
    ctl_wr(12'h504, 32'd2);
    ctl_wr(12'h50C, 32'd1);
    fl_rd(WPP + 44, 32'hFFFF_FFFF, "R7 flash cleared");
    ua_rd(9, 32'hFFFF_FFFF, "R7 ua cleared");

    // R9: user area register file
    cur_tag = "R9";
    ua_wr(0, 32'hA5A5_5A5A);
    ua_wr(63, 32'h0123_4567);
    ua_rd(0, 32'hA5A5_5A5A, "R9 word 0");
    ua_rd(63, 32'h0123_4567, "R9 word 63");
    ua_rd(1, 32'hFFFF_FFFF, "R9 neighbour");

    // R8: user-area erase ignores configuration
    cur_tag = "R8";
    ctl_wr(12'h514, 32'd3);
    ua_rd(0, 32'hA5A5_5A5A, "R8 wrong key ignored");
    ctl_wr(12'h504, 32'd0);
    ctl_wr(12'h514, 32'd1);
    ua_rd(0, 32'hFFFF_FFFF, "R8 cleared with erase-enable clear");
    ua_rd(63, 32'hFFFF_FFFF, "R8 last word cleared");

    // R11: erase wins over same-cycle write
    cur_tag = "R11";
    ctl_wr(12'h504, 32'd3);
    set_ctl(1, 12'h508, 32'h0);
    fl_valid = 1; fl_write = 1; fl_addr = FL_AW'(20 * 4); fl_wdata = 32'h0;
    step(); idle();
    fl_rd(20, 32'hFFFF_FFFF, "R11 flash erase wins");
    set_ctl(1, 12'h514, 32'd1);
    ua_valid = 1; ua_write = 1; ua_addr = 8'd12; ua_wdata = 32'h0;
    step(); idle();
    ua_rd(3, 32'hFFFF_FFFF, "R11 ua erase wins");

    // R10: read sees state before same-cycle erase
    cur_tag = "R10";
    fl_wr(5, 32'h0000_00AA);
    set_ctl(1, 12'h508, 32'h0);
    fl_valid = 1; fl_write = 0; fl_addr = FL_AW'(5 * 4);
    step(); idle();
    chk(fl_rdata, 32'h0000_00AA, "R10 read before erase");
    fl_rd(5, 32'hFFFF_FFFF, "R10 read after erase");

    // R12: flash survives reset
    cur_tag = "R12";
    fl_wr(40, 32'h0000_1234);
    rst_n = 0;
    step();
    rst_n = 1;
    fl_rd(40, 32'h0000_1234, "R12 flash kept");
    ctl_rd(12'h504, 32'd0, "R1 cfg cleared by second reset");

    repeat (2) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule